// File: doc/BRIEF.md
# Activity-timeout power-down controller

This block decides the power state of a serial line interface. It watches every transmitter-input and receiver-input line of the port. All of them pass through two-flop synchronizers, and a change on any one of them counts as activity. If no activity arrives for a full idle window, it switches off the supply pump and the line drivers. Two control pins sit on top of this automatic behaviour. `off_n` is an active-low forced shutdown that wins over everything else. `hold_on` is an active-high keep-alive that disables the automatic shutdown while it is high.

Once the interface has gone down, whether by force or by timeout, the idle timer stays expired. Only a new line change or a high `hold_on` brings the interface back up. When `hold_on` is released, the idle window restarts in full. This gives a slow peer a whole window in which to start talking.

After power-up, the drivers are held off for a settling time counted in clock cycles. The ready flag follows the pump and is further qualified by an external supply-good report. `off_n` and `hold_on` are synchronous to `clk`. The line inputs and `supply_good` may be asynchronous.

Top module: `lnk_pwr_ctrl`

## Requirements
- R1: The monitored lines are `tx_in` and `rx_in`, every bit. With `off_n`=1 and `hold_on`=0, a change on any monitored line reloads the idle window. If no further change arrives, `pump_en` falls at the clock edge that comes IDLE_CYC+2 edges after the edge that first samples the change.
- R2: While `off_n`=0, the outputs `pump_en`, `drv_en`, `rcv_oe` and `ready` are all 0 in the same cycle, whatever `hold_on` and the lines do.
- R3: While `off_n`=1 and `hold_on`=1, `pump_en` stays 1 however long the lines stay idle.
- R4: After any powerdown, `pump_en` stays 0 with `off_n`=1 and `hold_on`=0. It stays 0 until either `hold_on` rises (pump on in the same cycle) or a line changes (pump on 2 edges after the edge that samples the change). A line change seen while `off_n`=0 does not count as a wake-up.
- R5: `rcv_oe` is 0 during forced shutdown and 1 at all other times, including automatic powerdown.
- R6: `drv_en` rises only after `pump_en` has been 1 for WAKE_CYC consecutive clock edges. It drops in the same cycle as `pump_en`.
- R7: When `hold_on` falls with `off_n`=1 and the lines are idle, `pump_en` falls IDLE_CYC edges after the first edge that samples `hold_on`=0.
- R8: `ready` is 1 only when `pump_en` is 1 and `supply_good` has been sampled high through a two-flop synchronizer (2 edges). It falls in the same cycle as `pump_en`.
- R9: Reset leaves a full idle window loaded with the timer not expired. With `off_n`=1, this means `pump_en`=1 and `drv_en`=0 straight out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in | input | N_TX | Transmitter input lines, watched for changes |
| rx_in | input | N_RX | Receiver input lines, watched for changes |
| off_n | input | 1 | Forced shutdown, active low, overrides all |
| hold_on | input | 1 | Keep-alive, active high, disables automatic shutdown |
| supply_good | input | 1 | Negative supply has reached its working level |
| pump_en | output | 1 | Enables the supply pump |
| drv_en | output | 1 | Enables the line drivers (high-impedance when 0) |
| rcv_oe | output | 1 | Output enable of the standard receivers |
| ready | output | 1 | Interface ready to transmit |

## Verification
A wrong idle count shows up at `pump_en` as a shutdown that comes early or late by an exact number of edges. It is visible within a single idle window after the last line change or `hold_on` release. A lost expired latch shows up as `pump_en` coming back on its own after a powerdown, or after a line change made during forced shutdown. A missing reload shows up as a shutdown in the middle of random traffic whose gaps are shorter than the window. A broken settling counter moves the rising edge of `drv_en` away from exactly WAKE_CYC edges after the pump turns on.

// File: rtl/lnk_pwr_pkg.sv
`timescale 1ns/1ps
package lnk_pwr_pkg;
  // Power state of the interface as seen at the outputs.
  typedef enum logic [1:0] {
    PM_RUN        = 2'd0,  // pump on, drivers settled
    PM_SETTLE     = 2'd1,  // pump on, drivers still waiting
    PM_AUTO_OFF   = 2'd2,  // idle timer expired
    PM_FORCED_OFF = 2'd3   // forced shutdown pin asserted
  } pwr_mode_e;
endpackage

// File: rtl/lnk_line_watch.sv
`timescale 1ns/1ps
module lnk_line_watch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  output logic         activity
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic meta, stab, prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= 1'b0;
        stab <= 1'b0;
        prev <= 1'b0;
      end else begin
        meta <= lines[i];
        stab <= meta;
        prev <= stab;
      end
    end
    assign hit[i] = stab ^ prev;
  end

  assign activity = |hit;
endmodule

// File: rtl/lnk_idle_timer.sv
`timescale 1ns/1ps
module lnk_idle_timer #(
  parameter int IDLE_CYC = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off_n,
  input  logic hold_on,
  input  logic activity,
  output logic lapsed
);
  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(IDLE_CYC);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;
  logic          hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= FULL;
      lapsed <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= hold_on;
      if (!off_n) begin
        // forced shutdown leaves the timer expired
        lapsed <= 1'b1;
      end else if (hold_on || hold_q || activity) begin
        // keep-alive held or just released, or a line moved
        cnt    <= FULL;
        lapsed <= 1'b0;
      end else if (!lapsed) begin
        if (cnt <= ONE) begin
          lapsed <= 1'b1;
          cnt    <= '0;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/lnk_wake_timer.sv
`timescale 1ns/1ps
module lnk_wake_timer #(
  parameter int WAKE_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pump_on,
  output logic warm
);
  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam logic [WW-1:0] DONE = WW'(WAKE_CYC);

  logic [WW-1:0] wc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wc <= '0;
    else if (!pump_on)    wc <= '0;
    else if (wc != DONE)  wc <= wc + WW'(1);
  end

  assign warm = (wc == DONE);
endmodule

// File: rtl/lnk_pwr_ctrl.sv
`timescale 1ns/1ps
module lnk_pwr_ctrl
  import lnk_pwr_pkg::*;
#(
  parameter int N_TX     = 3,
  parameter int N_RX     = 5,
  parameter int IDLE_CYC = 30000,
  parameter int WAKE_CYC = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_TX-1:0] tx_in,
  input  logic [N_RX-1:0] rx_in,
  input  logic            off_n,
  input  logic            hold_on,
  input  logic            supply_good,
  output logic            pump_en,
  output logic            drv_en,
  output logic            rcv_oe,
  output logic            ready
);
  localparam int N_MON = N_TX + N_RX;

  logic [N_MON-1:0] mon_lines;
  logic             line_act;
  logic             lapsed;
  logic             warm;
  logic             sg_s1, sg_s2;
  pwr_mode_e        mode;

  assign mon_lines = {rx_in, tx_in};

  lnk_line_watch #(.N(N_MON)) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (mon_lines),
    .activity (line_act)
  );

  lnk_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .off_n    (off_n),
    .hold_on  (hold_on),
    .activity (line_act),
    .lapsed   (lapsed)
  );

  lnk_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .pump_on (pump_en),
    .warm    (warm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sg_s1 <= 1'b0;
      sg_s2 <= 1'b0;
    end else begin
      sg_s1 <= supply_good;
      sg_s2 <= sg_s1;
    end
  end

  always_comb begin
    if (!off_n)                 mode = PM_FORCED_OFF;
    else if (!hold_on && lapsed) mode = PM_AUTO_OFF;
    else if (warm)              mode = PM_RUN;
    else                        mode = PM_SETTLE;
  end

  assign pump_en = (mode == PM_RUN) || (mode == PM_SETTLE);
  assign drv_en  = (mode == PM_RUN);
  assign rcv_oe  = (mode != PM_FORCED_OFF);
  assign ready   = pump_en && sg_s2;
endmodule

// File: rtl/lnk_pwr_chk.sv
`timescale 1ns/1ps
module lnk_pwr_chk (
  input logic clk,
  input logic rst_n,
  input logic off_n,
  input logic hold_on,
  input logic activity,
  input logic sg_ok,
  input logic pump_en,
  input logic drv_en,
  input logic rcv_oe,
  input logic ready
);
  a_r2_forced_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    !off_n |-> (!pump_en && !drv_en && !rcv_oe && !ready));

  a_r3_keepalive_up: assert property (@(posedge clk) disable iff (!rst_n)
    (off_n && hold_on) |-> pump_en);

  a_r4_no_self_wake: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pump_en) && !hold_on) |-> ($past(activity) || $past(hold_on)));

  a_r1_lapse_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pump_en) && off_n) |-> !$past(activity));

  a_r5_rcv_on_unless_forced: assert property (@(posedge clk) disable iff (!rst_n)
    off_n |-> rcv_oe);

  a_r6_drv_after_pump: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> $past(pump_en));

  a_r8_ready_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (sg_ok && pump_en));
endmodule

bind lnk_pwr_ctrl lnk_pwr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .off_n    (off_n),
  .hold_on  (hold_on),
  .activity (line_act),
  .sg_ok    (sg_s2),
  .pump_en  (pump_en),
  .drv_en   (drv_en),
  .rcv_oe   (rcv_oe),
  .ready    (ready)
);

// File: tb/tb_lnk_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_lnk_pwr_ctrl;
  localparam int N_TX = 3;
  localparam int N_RX = 5;
  localparam int IDLE = 200;
  localparam int WAKE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_TX-1:0] tx_in = '0;
  logic [N_RX-1:0] rx_in = '0;
  logic off_n = 1'b1;
  logic hold_on = 1'b0;
  logic supply_good = 1'b0;
  logic pump_en, drv_en, rcv_oe, ready;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  lnk_pwr_ctrl #(.N_TX(N_TX), .N_RX(N_RX), .IDLE_CYC(IDLE), .WAKE_CYC(WAKE)) dut (
    .clk(clk), .rst_n(rst_n), .tx_in(tx_in), .rx_in(rx_in), .off_n(off_n),
    .hold_on(hold_on), .supply_good(supply_good), .pump_en(pump_en),
    .drv_en(drv_en), .rcv_oe(rcv_oe), .ready(ready));

  // Edges after the sampling edge at which the pump drops (R1, R7).
  function automatic int fall_delay(input bit by_keepalive);
    return by_keepalive ? IDLE : IDLE + 2;
  endfunction
  function automatic logic exp_rcv(input logic off_pin);
    return off_pin;
  endfunction
  function automatic logic exp_ready(input logic pump, input logic sg);
    return pump & sg;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flip(input int idx);
    if (idx < N_TX) tx_in[idx] = ~tx_in[idx];
    else            rx_in[idx - N_TX] = ~rx_in[idx - N_TX];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    rst_n = 1'b1;
    #1;
    chk("R9 pump after reset", pump_en, 1'b1);
    chk("R9 drv after reset", drv_en, 1'b0);
    chk("R5 rcv after reset", rcv_oe, exp_rcv(off_n));
    chk("R8 ready without supply", ready, 1'b0);

    cyc(WAKE - 1);
    chk("R6 drv before settle", drv_en, 1'b0);
    cyc(1);
    chk("R6 drv after settle", drv_en, 1'b1);

    supply_good = 1'b1;
    cyc(1);
    chk("R8 ready one edge after supply", ready, 1'b0);
    cyc(1);
    chk("R8 ready two edges after supply", ready, exp_ready(pump_en, 1'b1));

    // R1: random traffic with gaps inside the window keeps the pump on
    for (int k = 0; k < 25; k++) begin
      int gap;
      gap = 1 + int'($urandom % IDLE);
      flip(int'($urandom % (N_TX + N_RX)));
      cyc(gap);
      chk("R1 pump held by traffic", pump_en, 1'b1);
    end

    // R1: exact timeout after last change
    flip(N_TX + 2);
    cyc(fall_delay(1'b0));
    chk("R1 pump just before timeout", pump_en, 1'b1);
    cyc(1);
    chk("R1 pump at timeout", pump_en, 1'b0);
    chk("R6 drv drops with pump", drv_en, 1'b0);
    chk("R8 ready drops with pump", ready, exp_ready(pump_en, supply_good));
    chk("R5 rcv on in auto powerdown", rcv_oe, 1'b1);

    // R4: stays down while idle
    cyc(2 * IDLE);
    chk("R4 pump stays down", pump_en, 1'b0);

    // R4/R3: keep-alive wakes immediately and holds
    hold_on = 1'b1;
    #1;
    chk("R4 keepalive wakes at once", pump_en, 1'b1);
    cyc(3 * IDLE);
    chk("R3 pump held by keepalive", pump_en, 1'b1);
    chk("R3 drv held by keepalive", drv_en, 1'b1);

    // R7: keep-alive release restarts full window
    hold_on = 1'b0;
    cyc(fall_delay(1'b1));
    chk("R7 pump before window end", pump_en, 1'b1);
    cyc(1);
    chk("R7 pump at window end", pump_en, 1'b0);

    // R4/R6: line change wakes after sync delay, drivers after settle
    flip(0);
    cyc(2);
    chk("R4 pump before edge seen", pump_en, 1'b0);
    cyc(1);
    chk("R4 pump after edge wake", pump_en, 1'b1);
    chk("R6 drv not yet on", drv_en, 1'b0);
    cyc(WAKE - 1);
    chk("R6 drv one short of settle", drv_en, 1'b0);
    cyc(1);
    chk("R6 drv after wake settle", drv_en, 1'b1);

    // R2: forced shutdown beats keep-alive
    off_n = 1'b0;
    hold_on = 1'b1;
    #1;
    chk("R2 pump forced off", pump_en, 1'b0);
    chk("R2 drv forced off", drv_en, 1'b0);
    chk("R2 rcv forced off", rcv_oe, exp_rcv(off_n));
    chk("R2 ready forced off", ready, 1'b0);
    cyc(5);
    chk("R2 pump off despite keepalive", pump_en, 1'b0);
    hold_on = 1'b0;
    flip(N_TX + N_RX - 1);
    cyc(6);
    chk("R2 pump off despite line change", pump_en, 1'b0);

    // R4: manual powerdown leaves timer expired
    off_n = 1'b1;
    #1;
    chk("R4 pump down after force release", pump_en, 1'b0);
    chk("R5 rcv back after force release", rcv_oe, 1'b1);
    cyc(IDLE);
    chk("R4 pump still down idle", pump_en, 1'b0);
    flip(1);
    cyc(2);
    chk("R4 pump before edge after force", pump_en, 1'b0);
    cyc(1);
    chk("R4 pump woken after force", pump_en, 1'b1);
    chk("R8 ready follows pump", ready, exp_ready(pump_en, supply_good));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule